// File: doc/BRIEF.md
# DMA Burst Transfer Cycle Limiter

This block caps how many system-memory data transfers a bus master makes during one bus tenure. An 8-bit limit register is copied into a down-counter whenever a new DMA cycle begins. Each counted transfer strobe lowers the count by one. When the count is used up, the block raises a one-cycle bus-release pulse. The bus owner uses that pulse to hand the bus back to the arbiter. Arbitration itself happens outside the block.

Linear bursts must not be cut in half. If the count reaches zero in the middle of a burst, the block keeps letting transfers through. It releases only after the transfer that brings the address to the next legal burst start. A legal burst start is an address aligned to the burst length times the transfer size.

Descriptor accesses are never counted. A disable input suppresses release entirely. A test-mode input turns every register write into a decrement of the running count.

Top module: `dma_xfer_limiter`

## Requirements
- R1: After reset the limit register holds 16 and the counter holds 16, so the first DMA cycle releases after 16 transfers when it starts on a burst boundary.
- R2: A register write with `test_mode` low stores `cfg_wr_data`. The value takes effect at the next `cycle_start`, and a value of N releases after N transfers when the cycle starts on a burst boundary and N is a multiple of `BURST_LEN`.
- R3: A stored limit of zero behaves as a limit of one transfer.
- R4: A strobe with `xfer_desc` high neither changes the count nor causes a release.
- R5: While `limit_off` is high, `bus_release` is never asserted.
- R6: A register write with `test_mode` high lowers the running count by one, saturating at zero, and leaves the stored limit unchanged.
- R7: Release is held off until the count is zero and a counted transfer ends on a burst start. That is, (`xfer_addr` + `XFER_BYTES`) is a multiple of `BURST_LEN`*`XFER_BYTES` (16 bytes by default). `bus_release` rises in the cycle after that transfer's strobe.
- R8: `bus_release` is a single-cycle pulse and fires at most once per DMA cycle. The count stops at zero and never wraps.
- R9: `cycle_start` reloads the counter from the stored limit and re-arms release. It has priority over a strobe in the same cycle, and that strobe is not counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr_en | input | 1 | Limit register write strobe |
| cfg_wr_data | input | 8 | Limit register write data |
| limit_off | input | 1 | Suppresses count-based bus release |
| test_mode | input | 1 | Turns register writes into count decrements |
| cycle_start | input | 1 | Start of a new DMA cycle; reloads the counter |
| xfer_valid | input | 1 | One memory transfer occurs this cycle |
| xfer_addr | input | ADDR_W | Byte address of the transfer |
| xfer_desc | input | 1 | Transfer is a descriptor access |
| bus_release | output | 1 | One-cycle request to give up the bus |

## Verification
The only result is `bus_release`, which is registered. It is due exactly one clock after the edge that captures the deciding transfer strobe. The bench drives every strobe on a falling edge and reads `bus_release` on the next falling edge. Each observed pulse is therefore tied to the transfer just issued, and its position in the burst is counted in transfers. Expected transfer counts come from arithmetic on the start offset and the effective limit. The bench also checks the falling edge after each pulse, to confirm that the pulse lasts a single cycle.

// File: rtl/dxl_pkg.sv
package dxl_pkg;
  // Effective limit: zero is treated as one transfer
  function automatic int unsigned lim_effective(int unsigned v);
    return (v == 0) ? 1 : v;
  endfunction

  // Saturating subtract
  function automatic int unsigned sat_sub(int unsigned c, int unsigned d);
    return (c > d) ? (c - d) : 0;
  endfunction

  // True when a transfer at byte offset low_bits ends on an align boundary
  function automatic logic ends_on_boundary(int unsigned low_bits,
                                            int unsigned xfer_bytes,
                                            int unsigned align);
    return ((low_bits + xfer_bytes) % align) == 0;
  endfunction
endpackage

// File: rtl/dxl_limit_reg.sv
module dxl_limit_reg #(
  parameter int LIM_W     = 8,
  parameter int RESET_VAL = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [LIM_W-1:0] wr_data,
  input  logic             test_mode,
  output logic [LIM_W-1:0] lim_q,
  output logic             test_dec
);
  logic load_ok;
  assign load_ok  = wr_en && !test_mode;
  assign test_dec = wr_en && test_mode;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       lim_q <= LIM_W'(RESET_VAL);
    else if (load_ok) lim_q <= wr_data;
  end
endmodule

// File: rtl/dxl_counter.sv
module dxl_counter #(
  parameter int CNT_W     = 8,
  parameter int RESET_VAL = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic [1:0]       dec_amt,
  output logic [CNT_W-1:0] cnt_q,
  output logic [CNT_W-1:0] cnt_after
);
  import dxl_pkg::*;

  always_comb begin
    if (load) cnt_after = load_val;
    else      cnt_after = CNT_W'(sat_sub(int'(cnt_q), int'(dec_amt)));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= CNT_W'(RESET_VAL);
    else        cnt_q <= cnt_after;
  end
endmodule

// File: rtl/dxl_boundary.sv
module dxl_boundary #(
  parameter int ADDR_W     = 16,
  parameter int BURST_LEN  = 4,
  parameter int XFER_BYTES = 4
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              ends_at_start
);
  import dxl_pkg::*;
  localparam int ALIGN = BURST_LEN * XFER_BYTES;
  localparam int AL_W  = (ALIGN > 1) ? $clog2(ALIGN) : 1;

  logic [AL_W-1:0] low;
  assign low           = addr[AL_W-1:0];
  assign ends_at_start = ends_on_boundary(int'(low), XFER_BYTES, ALIGN);
endmodule

// File: rtl/dma_xfer_limiter.sv
module dma_xfer_limiter #(
  parameter int LIM_W      = 8,
  parameter int ADDR_W     = 16,
  parameter int BURST_LEN  = 4,
  parameter int XFER_BYTES = 4,
  parameter int RESET_LIM  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr_en,
  input  logic [LIM_W-1:0]  cfg_wr_data,
  input  logic              limit_off,
  input  logic              test_mode,
  input  logic              cycle_start,
  input  logic              xfer_valid,
  input  logic [ADDR_W-1:0] xfer_addr,
  input  logic              xfer_desc,
  output logic              bus_release
);
  import dxl_pkg::*;

  // Named internal events
  logic [LIM_W-1:0] lim_q;
  logic             test_dec;
  logic [LIM_W-1:0] cnt_q, cnt_after, load_val;
  logic             strobe_cnt, bnd_hit, fire, rel_done;
  logic [1:0]       dec_amt;

  dxl_limit_reg #(.LIM_W(LIM_W), .RESET_VAL(RESET_LIM)) reg_i (
    .clk(clk), .rst_n(rst_n), .wr_en(cfg_wr_en), .wr_data(cfg_wr_data),
    .test_mode(test_mode), .lim_q(lim_q), .test_dec(test_dec)
  );

  assign strobe_cnt = xfer_valid && !xfer_desc && !cycle_start;
  assign dec_amt    = {1'b0, strobe_cnt} + {1'b0, test_dec};
  assign load_val   = LIM_W'(lim_effective(int'(lim_q)));

  dxl_counter #(.CNT_W(LIM_W), .RESET_VAL(RESET_LIM)) cnt_i (
    .clk(clk), .rst_n(rst_n), .load(cycle_start), .load_val(load_val),
    .dec_amt(dec_amt), .cnt_q(cnt_q), .cnt_after(cnt_after)
  );

  dxl_boundary #(.ADDR_W(ADDR_W), .BURST_LEN(BURST_LEN),
                 .XFER_BYTES(XFER_BYTES)) bnd_i (
    .addr(xfer_addr), .ends_at_start(bnd_hit)
  );

  assign fire = strobe_cnt && bnd_hit && (cnt_after == '0) &&
                !limit_off && !rel_done;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_release <= 1'b0;
      rel_done    <= 1'b0;
    end else begin
      bus_release <= fire;
      if (cycle_start) rel_done <= 1'b0;
      else if (fire)   rel_done <= 1'b1;
    end
  end
endmodule

// File: rtl/dxl_checker.sv
module dxl_checker #(
  parameter int LIM_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cycle_start,
  input logic             xfer_valid,
  input logic             xfer_desc,
  input logic             limit_off,
  input logic             cfg_wr_en,
  input logic             test_mode,
  input logic             bus_release,
  input logic             bnd_hit,
  input logic [LIM_W-1:0] cnt_q,
  input logic [LIM_W-1:0] lim_q
);
  a_r8_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    bus_release |=> !bus_release);

  a_r7_release_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
    bus_release |-> (cnt_q == '0));

  a_r7_release_on_boundary: assert property (@(posedge clk) disable iff (!rst_n)
    bus_release |-> $past(xfer_valid && !xfer_desc && bnd_hit));

  a_r5_no_release_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    bus_release |-> !$past(limit_off));

  a_r8_no_count_rise: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(cycle_start) |-> (cnt_q <= $past(cnt_q)));

  a_r4_desc_uncounted: assert property (@(posedge clk) disable iff (!rst_n)
    $past(xfer_valid && xfer_desc && !cycle_start && !(cfg_wr_en && test_mode))
      |-> (cnt_q == $past(cnt_q)));

  a_r6_test_write_keeps_reg: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cfg_wr_en && test_mode) |-> (lim_q == $past(lim_q)));

  a_r9_reload_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    cycle_start |=> (cnt_q != '0));
endmodule

bind dma_xfer_limiter dxl_checker #(.LIM_W(LIM_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .cycle_start(cycle_start), .xfer_valid(xfer_valid),
  .xfer_desc(xfer_desc), .limit_off(limit_off), .cfg_wr_en(cfg_wr_en),
  .test_mode(test_mode), .bus_release(bus_release), .bnd_hit(bnd_hit),
  .cnt_q(cnt_q), .lim_q(lim_q)
);

// File: tb/dma_xfer_limiter_tb.sv
module dma_xfer_limiter_tb_top;
  localparam int ADDR_W = 16;
  localparam int BL = 4;
  localparam int XB = 4;
  localparam int ALIGN = BL * XB;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_wr_en = 1'b0;
  logic [7:0] cfg_wr_data = '0;
  logic limit_off = 1'b0;
  logic test_mode = 1'b0;
  logic cycle_start = 1'b0;
  logic xfer_valid = 1'b0;
  logic [ADDR_W-1:0] xfer_addr = '0;
  logic xfer_desc = 1'b0;
  logic bus_release;

  int n_cmp = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  dma_xfer_limiter dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_wr_data(cfg_wr_data),
    .limit_off(limit_off), .test_mode(test_mode), .cycle_start(cycle_start),
    .xfer_valid(xfer_valid), .xfer_addr(xfer_addr), .xfer_desc(xfer_desc),
    .bus_release(bus_release)
  );

  task automatic check(string req, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cfg_write(input logic [7:0] v, input logic tm);
    @(negedge clk);
    cfg_wr_en = 1'b1; cfg_wr_data = v; test_mode = tm;
    @(negedge clk);
    cfg_wr_en = 1'b0; test_mode = 1'b0;
  endtask

  task automatic start_cycle();
    @(negedge clk);
    cycle_start = 1'b1;
    @(negedge clk);
    cycle_start = 1'b0;
  endtask

  // Issue one strobe; rel is bus_release one clock later.
  task automatic xfer(input int addr, input logic desc, output logic rel);
    xfer_valid = 1'b1; xfer_addr = ADDR_W'(addr); xfer_desc = desc;
    @(negedge clk);
    rel = bus_release;
    xfer_valid = 1'b0; xfer_desc = 1'b0;
  endtask

  // Runs counted transfers from word offset s; returns index of release (0 = none)
  task automatic run_burst(input int s, input int max_n, output int hit, output int extra);
    logic r;
    hit = 0; extra = 0;
    @(negedge clk);
    for (int k = 1; k <= max_n; k++) begin
      xfer(32'h100 + (s + k - 1) * XB, 1'b0, r);
      if (r) begin
        if (hit == 0) hit = k; else extra++;
      end
    end
    @(negedge clk);
  endtask

  function automatic int exp_hits(int lim, int s);
    int e = (lim == 0) ? 1 : lim;
    for (int k = e; k < e + BL + 1; k++)
      if (((s + k) * XB) % ALIGN == 0) return k;
    return -1;
  endfunction

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin : main
    int hit, extra;
    logic r;
    repeat (3) @(negedge clk);
    check("R8 reset state", int'(bus_release), 0);
    rst_n = 1'b1;

    // R1: reset limit of 16, no cycle_start
    run_burst(0, 24, hit, extra);
    check("R1 reset limit", hit, 16);

    // R2 R3 R7 R8 R9: sweep limits and start offsets
    for (int lim = 0; lim <= 20; lim++) begin
      cfg_write(8'(lim), 1'b0);
      for (int s = 0; s < BL; s++) begin
        start_cycle();
        run_burst(s, 30, hit, extra);
        if (lim == 0)
          check("R3 zero as one", hit, exp_hits(lim, s));
        else if (s == 0 && lim % BL == 0)
          check("R2 limit load", hit, lim);
        else
          check("R7 boundary holdoff", hit, exp_hits(lim, s));
        check("R8 once per cycle", extra, 0);
      end
    end

    // R8: pulse lasts one cycle
    cfg_write(8'd4, 1'b0);
    start_cycle();
    for (int k = 0; k < 4; k++) xfer(32'h200 + k * XB, 1'b0, r);
    check("R8 pulse high", int'(r), 1);
    @(negedge clk);
    check("R8 pulse one cycle", int'(bus_release), 0);

    // R4: descriptor strobes do not count or release
    start_cycle();
    xfer(32'h300, 1'b0, r);
    xfer(32'h304, 1'b0, r);
    for (int k = 0; k < 3; k++) begin
      xfer(32'h30C, 1'b1, r);
      check("R4 desc no release", int'(r), 0);
    end
    xfer(32'h308, 1'b0, r);
    check("R4 not yet", int'(r), 0);
    xfer(32'h30C, 1'b0, r);
    check("R4 release on 4th counted", int'(r), 1);

    // R5: disable suppresses release
    limit_off = 1'b1;
    start_cycle();
    run_burst(0, 40, hit, extra);
    check("R5 disabled no release", hit, 0);
    limit_off = 1'b0;

    // R6: test-mode writes decrement; register kept
    cfg_write(8'd8, 1'b0);
    start_cycle();
    for (int k = 0; k < 4; k++) cfg_write(8'hFF, 1'b1);
    run_burst(0, 12, hit, extra);
    check("R6 test decrement", hit, 4);
    start_cycle();
    run_burst(0, 12, hit, extra);
    check("R6 register unchanged", hit, 8);

    // R6: saturation at zero via test writes
    cfg_write(8'd2, 1'b0);
    start_cycle();
    for (int k = 0; k < 5; k++) cfg_write(8'h00, 1'b1);
    run_burst(1, 8, hit, extra);
    check("R6 saturating test dec", hit, 3);

    // R9: cycle_start beats a same-cycle strobe
    cfg_write(8'd4, 1'b0);
    @(negedge clk);
    cycle_start = 1'b1; xfer_valid = 1'b1; xfer_addr = 16'h40C;
    @(negedge clk);
    cycle_start = 1'b0; xfer_valid = 1'b0;
    run_burst(0, 8, hit, extra);
    check("R9 start priority", hit, 4);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule